// File: doc/BRIEF.md
# Key-Protected Time-of-Day Counter

This block keeps the time of day in four cascaded byte-wide counters: hundredths of a second, seconds, minutes and hours. Its clock is the 32.768 kHz timebase itself. A fractional accumulator turns that timebase into an average of exactly 100 hundredths ticks per second, with no drift that builds up over time. Each counter that reaches its limit returns to zero and carries one count into the next counter on the same clock edge.

A host reaches the block through a single-cycle register write port and a combinational read port. The counters never stop, and a read returns the live value. A time counter accepts a write only while a key register holds the unlock value. The key clears itself after every accepted time write, so stray writes cannot disturb the time. A configuration register selects whether the hour counter wraps at 24 or at 256. A write to the hour-mode setting passes through a 128 Hz update domain before it takes effect. When the hour counter rolls over, the block raises a one-cycle midnight pulse and sets a sticky midnight flag. That flag serves as the pending interrupt request.

Register addresses: 0 hundredths, 1 seconds, 2 minutes, 3 hours, 4 configuration (bit 0 hour mode, bit 7 midnight flag), 5 key. Addresses 6 and 7 read as zero.

Top module: `rtc_keyed_core`

## Requirements
- R1: After reset all four time counters, the key, the hour mode and the midnight flag read 0.
- R2: The hundredths counter advances only on the tick of an accumulator. Each clock adds 100, and a tick fires when the sum reaches 32768, which then subtracts 32768. With the accumulator at 0 after reset, the first advance comes on the 328th clock edge.
- R3: On an advance, a counter at or above its limit returns to 0 and carries into the next counter on the same edge. The limits are 99 for hundredths and 59 for seconds and minutes.
- R4: A write to address 0 to 3 loads that counter only while the key reads 0xEA. A write to address 5 loads the key, and the key reads back at address 5.
- R5: The key returns to 0 on the edge that accepts a time counter write. In that cycle no counter advances.
- R6: A time counter write made while the key does not read 0xEA changes no counter and leaves the key unchanged.
- R7: With hour mode 0 the hour counter wraps from 23 to 0. With hour mode 1 it counts on through 24 and wraps from 255 to 0.
- R8: An hour wrap drives midnight_evt high for exactly one cycle and sets midnight_flag. Both become visible together with the hour reading 0.
- R9: midnight_flag clears only when the host writes address 4 with bit 7 at 0. A write with bit 7 at 1 leaves it set. A new midnight wins over a clear in the same cycle.
- R10: A strobe fires every 256 clocks. Written hour-mode bit 0 takes effect on the second strobe after the write, so the delay is 257 to 512 clocks. A later configuration write restarts that count.
- R11: Reads neither stop nor delay the counters. rd_data shows the addressed register combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 32.768 kHz timebase clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Single-cycle register write strobe |
| wr_addr | input | 3 | Write register address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read register address |
| rd_data | output | 8 | Addressed register value |
| midnight_evt | output | 1 | One-cycle pulse on hour wrap |
| midnight_flag | output | 1 | Sticky midnight flag / pending request |

## Verification
The assertions assume that the tick rate is below half the clock rate, so two advances are never adjacent. They also assume that a write strobe lasts one cycle and that the inputs are known once reset is released. The stimulus drives every write as a single-cycle pulse away from the clock edge and holds wr_en low otherwise. It reaches rollovers by loading counters close to their limits through the key sequence, not by waiting whole hours. The 256-hour wrap is reached only after the mode change has had time to pass through both update strobes.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned ADDR_W = 3;
  localparam logic [DATA_W-1:0] UNLOCK_KEY = 8'hEA;
  localparam int unsigned CFG_MODE_BIT = 0;
  localparam int unsigned CFG_FLAG_BIT = 7;

  typedef logic [DATA_W-1:0] rtc_byte_t;

  typedef enum logic [ADDR_W-1:0] {
    A_HS   = 3'd0,
    A_SEC  = 3'd1,
    A_MIN  = 3'd2,
    A_HOUR = 3'd3,
    A_CFG  = 3'd4,
    A_KEY  = 3'd5
  } rtc_addr_e;

  // true when a counter must wrap on its next advance
  function automatic logic at_limit(rtc_byte_t value, rtc_byte_t limit);
    return value >= limit;
  endfunction

  // value after one advance
  function automatic rtc_byte_t step(rtc_byte_t value, rtc_byte_t limit);
    return at_limit(value, limit) ? '0 : rtc_byte_t'(value + 1'b1);
  endfunction

  // hour limit selected by the mode bit
  function automatic rtc_byte_t hour_limit(logic long_mode, int unsigned day_hours);
    return long_mode ? '1 : rtc_byte_t'(day_hours - 1);
  endfunction
endpackage

// File: rtl/rtc_tick_gen.sv
module rtc_tick_gen #(
  parameter int unsigned CLK_HZ  = 32768,
  parameter int unsigned TICK_HZ = 100,
  parameter int unsigned SLOW_HZ = 128
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick,
  output logic slow_stb
);
  localparam int unsigned ACC_W = $clog2(CLK_HZ + TICK_HZ) + 1;
  localparam int unsigned DIV_N = CLK_HZ / SLOW_HZ;
  localparam int unsigned DIV_W = (DIV_N > 1) ? $clog2(DIV_N) : 1;

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_sum;
  logic [DIV_W-1:0] div_q;

  assign acc_sum  = acc_q + ACC_W'(TICK_HZ);
  assign tick     = acc_sum >= ACC_W'(CLK_HZ);
  assign slow_stb = div_q == DIV_W'(DIV_N - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
      div_q <= '0;
    end else begin
      acc_q <= tick ? ACC_W'(acc_sum - ACC_W'(CLK_HZ)) : acc_sum;
      div_q <= slow_stb ? '0 : DIV_W'(div_q + 1'b1);
    end
  end
endmodule

// File: rtl/rtc_digit.sv
module rtc_digit
  import rtc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      inc,
  input  logic      load,
  input  rtc_byte_t load_val,
  input  rtc_byte_t limit,
  output rtc_byte_t value,
  output logic      at_top
);
  assign at_top = at_limit(value, limit);

  always_ff @(posedge clk) begin
    if (!rst_n)      value <= '0;
    else if (load)   value <= load_val;
    else if (inc)    value <= step(value, limit);
  end
endmodule

// File: rtl/rtc_cfg_sync.sv
module rtc_cfg_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic wr_mode,
  input  logic slow_stb,
  output logic mode
);
  logic       pend_q;
  logic [1:0] stage_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      stage_q <= 2'd0;
      mode    <= 1'b0;
    end else if (wr) begin
      pend_q  <= wr_mode;
      stage_q <= 2'd2;
    end else if (slow_stb && stage_q != 2'd0) begin
      stage_q <= stage_q - 2'd1;
      if (stage_q == 2'd1) mode <= pend_q;
    end
  end
endmodule

// File: rtl/rtc_keyed_core.sv
module rtc_keyed_core
  import rtc_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 32768,
  parameter int unsigned TICK_HZ     = 100,
  parameter int unsigned SLOW_HZ     = 128,
  parameter int unsigned SUB_PER_MIN = 60,
  parameter int unsigned DAY_HOURS   = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              midnight_evt,
  output logic              midnight_flag
);
  localparam int unsigned NDIG = 4;

  logic      tick;
  logic      slow_stb;
  rtc_byte_t key_q;
  logic      mode_q;
  logic      time_sel;
  logic      time_wr_ok;
  logic      cfg_wr;
  logic      midnight_raw;
  rtc_byte_t hour_q;

  rtc_byte_t       lim [NDIG];
  rtc_byte_t       val [NDIG];
  logic [NDIG-1:0] top;
  logic [NDIG:0]   adv;

  rtc_tick_gen #(.CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ), .SLOW_HZ(SLOW_HZ)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick), .slow_stb(slow_stb)
  );

  assign time_sel   = wr_addr <= ADDR_W'(A_HOUR);
  assign time_wr_ok = wr_en && time_sel && (key_q == UNLOCK_KEY);
  assign cfg_wr     = wr_en && (wr_addr == ADDR_W'(A_CFG));

  always_comb begin
    lim[0] = rtc_byte_t'(TICK_HZ - 1);
    lim[1] = rtc_byte_t'(SUB_PER_MIN - 1);
    lim[2] = rtc_byte_t'(SUB_PER_MIN - 1);
    lim[3] = hour_limit(mode_q, DAY_HOURS);
  end

  assign adv[0] = tick && !time_wr_ok;

  for (genvar i = 0; i < NDIG; i++) begin : g_dig
    rtc_digit u_dig (
      .clk(clk), .rst_n(rst_n),
      .inc(adv[i]),
      .load(time_wr_ok && (wr_addr == ADDR_W'(i))),
      .load_val(wr_data),
      .limit(lim[i]),
      .value(val[i]),
      .at_top(top[i])
    );
    assign adv[i+1] = adv[i] && top[i];
  end

  assign midnight_raw = adv[NDIG];
  assign hour_q       = val[3];

  rtc_cfg_sync u_cfg (
    .clk(clk), .rst_n(rst_n),
    .wr(cfg_wr), .wr_mode(wr_data[CFG_MODE_BIT]),
    .slow_stb(slow_stb), .mode(mode_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      key_q         <= '0;
      midnight_flag <= 1'b0;
      midnight_evt  <= 1'b0;
    end else begin
      if (wr_en && wr_addr == ADDR_W'(A_KEY)) key_q <= wr_data;
      else if (time_wr_ok)                    key_q <= '0;
      if (midnight_raw)                               midnight_flag <= 1'b1;
      else if (cfg_wr && !wr_data[CFG_FLAG_BIT])      midnight_flag <= 1'b0;
      midnight_evt <= midnight_raw;
    end
  end

  always_comb begin
    rd_data = '0;
    case (rtc_addr_e'(rd_addr))
      A_HS:    rd_data = val[0];
      A_SEC:   rd_data = val[1];
      A_MIN:   rd_data = val[2];
      A_HOUR:  rd_data = val[3];
      A_CFG: begin
        rd_data[CFG_MODE_BIT] = mode_q;
        rd_data[CFG_FLAG_BIT] = midnight_flag;
      end
      A_KEY:   rd_data = key_q;
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/rtc_keyed_chk.sv
module rtc_keyed_chk
  import rtc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] key_q,
  input logic [DATA_W-1:0] hour_q,
  input logic              tick,
  input logic              slow_stb,
  input logic              mode_q,
  input logic              midnight_evt,
  input logic              midnight_flag
);
  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R2
  AST_KEY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr <= 3'd3 && key_q == UNLOCK_KEY) |=> key_q == 8'd0); // R5
  AST_LOCKED_KEY_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr <= 3'd3 && key_q != UNLOCK_KEY) |=> key_q == $past(key_q)); // R6
  AST_EVT_HOUR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    midnight_evt |-> hour_q == 8'd0); // R7
  AST_EVT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    midnight_evt |=> !midnight_evt); // R8
  AST_EVT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    midnight_evt |-> midnight_flag); // R8
  AST_FLAG_CLEAR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(midnight_flag) |-> $past(wr_en && wr_addr == 3'd4 && !wr_data[CFG_FLAG_BIT])); // R9
  AST_MODE_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != $past(mode_q)) |-> $past(slow_stb)); // R10
endmodule

bind rtc_keyed_core rtc_keyed_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .key_q(key_q), .hour_q(hour_q), .tick(tick), .slow_stb(slow_stb),
  .mode_q(mode_q), .midnight_evt(midnight_evt), .midnight_flag(midnight_flag)
);

// File: tb/sim_rtc_keyed_core.sv
module sim_rtc_keyed_core;
  localparam time CLK_PERIOD = 30518ns;
  localparam int CLK_HZ = 32768;
  localparam int TICK_HZ = 100;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       midnight_evt;
  logic       midnight_flag;

  int tests = 0;
  int fails = 0;
  bit armed = 0;
  bit done = 0;

  // behavioural reference state
  int m_hs, m_sec, m_min, m_hr, m_key, m_acc, m_div, m_mode, m_pend, m_stage, m_flag, m_evt;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_keyed_core u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .midnight_evt(midnight_evt), .midnight_flag(midnight_flag)
  );

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int model_read(int a);
    case (a)
      0: return m_hs;
      1: return m_sec;
      2: return m_min;
      3: return m_hr;
      4: return m_flag * 128 + m_mode;
      5: return m_key;
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(int a);
    case (a)
      0: return "R2 hundredths";
      1, 2: return "R3 sec/min";
      3: return "R7 hours";
      4: return "R10 config";
      5: return "R5 key";
      default: return "R11 unused address";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_hs = 0; m_sec = 0; m_min = 0; m_hr = 0; m_key = 0; m_acc = 0; m_div = 0;
      m_mode = 0; m_pend = 0; m_stage = 0; m_flag = 0; m_evt = 0;
    end else begin
      bit tk, stb, accepted, mid;
      int hl;
      tk = (m_acc + TICK_HZ) >= CLK_HZ;
      m_acc = tk ? m_acc + TICK_HZ - CLK_HZ : m_acc + TICK_HZ;
      stb = (m_div == 255);
      m_div = stb ? 0 : m_div + 1;
      accepted = wr_en && wr_addr <= 3 && m_key == 'hEA;
      mid = 0;
      hl = m_mode ? 255 : 23;
      if (accepted) begin
        case (wr_addr)
          0: m_hs = wr_data;
          1: m_sec = wr_data;
          2: m_min = wr_data;
          default: m_hr = wr_data;
        endcase
      end else if (tk) begin
        if (m_hs < 99) m_hs++;
        else begin
          m_hs = 0;
          if (m_sec < 59) m_sec++;
          else begin
            m_sec = 0;
            if (m_min < 59) m_min++;
            else begin
              m_min = 0;
              if (m_hr < hl) m_hr++;
              else begin m_hr = 0; mid = 1; end
            end
          end
        end
      end
      if (wr_en && wr_addr == 5) m_key = wr_data;
      else if (accepted) m_key = 0;
      if (mid) m_flag = 1;
      else if (wr_en && wr_addr == 4 && !wr_data[7]) m_flag = 0;
      m_evt = mid;
      if (wr_en && wr_addr == 4) begin
        m_pend = wr_data[0];
        m_stage = 2;
      end else if (stb && m_stage != 0) begin
        if (m_stage == 1) m_mode = m_pend;
        m_stage--;
      end
    end
  end

  // every-cycle comparison against the reference
  always @(negedge clk) begin
    if (armed) begin
      chk(tag_of(rd_addr), rd_data, model_read(rd_addr));
      chk("R8 midnight_evt", midnight_evt, m_evt);
      chk("R9 midnight_flag", midnight_flag, m_flag);
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk); #1;
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 8'(d);
    @(negedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic keyed_wr(int a, int d);
    wr(5, 'hEA);
    wr(a, d);
  endtask

  task automatic peek(int a, output int v);
    @(negedge clk); #1;
    rd_addr = 3'(a);
    #1 v = rd_data;
  endtask

  task automatic wait_cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int v, v2;
    repeat (3) @(posedge clk);
    @(negedge clk); #1 rst_n = 1'b1;
    armed = 1;

    // R1: reset state at every address
    for (int a = 0; a < 6; a++) begin
      peek(a, v);
      chk($sformatf("R1 reset addr %0d", a), v, 0);
    end

    // R2: first hundredths advance on the 328th edge, watched every cycle
    rd_addr = 3'd0;
    wait_cycles(400);
    peek(0, v);
    chk("R2 hundredths advanced once", v, 1);

    // R6: locked write ignored, key kept
    wr(5, 'h13);
    wr(1, 30);
    peek(1, v);  chk("R6 locked seconds unchanged", v, 0);
    peek(5, v);  chk("R6 key kept after locked write", v, 'h13);

    // R4 / R5: unlocked write then self-clearing key
    wr(5, 'hEA);
    peek(5, v);  chk("R4 key reads unlock value", v, 'hEA);
    wr(1, 42);
    peek(1, v);  chk("R4 seconds loaded", v, 42);
    peek(5, v);  chk("R5 key cleared after write", v, 0);
    wr(2, 7);
    peek(2, v);  chk("R5 second write needs new key", v, 0);

    // R11: counters keep running across reads
    peek(0, v);
    wait_cycles(700);
    peek(0, v2);
    chk("R11 hundredths moved while read", (v2 != v) ? 1 : 0, 1);

    // R3 / R7 / R8: day rollover in 24-hour mode
    keyed_wr(3, 23);
    keyed_wr(2, 59);
    keyed_wr(1, 59);
    keyed_wr(0, 99);
    rd_addr = 3'd3;
    wait_cycles(400);
    peek(3, v);  chk("R7 hour wrapped 23->0", v, 0);
    peek(2, v);  chk("R3 minutes wrapped", v, 0);
    peek(4, v);  chk("R8 flag set in config", v, 128);

    // R9: writing 1 keeps the flag, writing 0 clears it
    wr(4, 'h80);
    peek(4, v);  chk("R9 flag survives bit7=1 write", v >> 7, 1);
    wr(4, 'h00);
    peek(4, v);  chk("R9 flag cleared by bit7=0 write", v >> 7, 0);

    // R10: hour mode takes two slow strobes
    wr(4, 'h01);
    wait_cycles(100);
    peek(4, v);  chk("R10 mode not yet applied", v & 1, 0);
    wait_cycles(450);
    peek(4, v);  chk("R10 mode applied", v & 1, 1);

    // R7: 256-hour mode passes 23 and wraps at 255
    keyed_wr(3, 23);
    keyed_wr(2, 59);
    keyed_wr(1, 59);
    keyed_wr(0, 99);
    wait_cycles(400);
    peek(3, v);  chk("R7 hour 23->24 in long mode", v, 24);
    chk("R8 no midnight at 24 in long mode", midnight_flag, 0);
    keyed_wr(3, 255);
    keyed_wr(2, 59);
    keyed_wr(1, 59);
    keyed_wr(0, 99);
    rd_addr = 3'd3;
    wait_cycles(400);
    peek(3, v);  chk("R7 hour wrapped 255->0", v, 0);
    chk("R8 flag after long wrap", midnight_flag, 1);

    // R11: unused address reads zero
    peek(7, v);  chk("R11 unused address", v, 0);

    wait_cycles(5);
    finish_run();
  end
endmodule